// File: doc/BRIEF.md
# Quad I/O Execute-in-Place Read Sequencer

This block sits on the host side of a serial NOR flash and turns fetch requests (a 24-bit address and a byte count) into quad-I/O single-data-rate read frames. It produces the serial clock at half the system clock, frames each transaction with the active-low chip select, and drives the four data lines with a separate output enable for each. Read data comes back as a byte stream on `rd_data` with a one-cycle `rd_valid` strobe, and `done` pulses once the whole request has finished.

The sequencer always drives the byte that follows the address itself. A fetch can ask to keep the flash in continuous-read state. In that case the sequencer sends A0h there and records the fact in `cont_mode`, and the next fetch leaves out the opcode and starts directly with the address. A fetch without that request sends 00h, which takes the flash out of that state. Because the lines are never left floating at that point, an address whose low nibble happens to be 1010b cannot start continuous reads by accident. Two maintenance requests are provided: a mode-exit frame that drives all four lines high for eight clocks, and a software reset, which is two separately framed commands.

Top module: `qspi_xip_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `io_oe` is 0000b, `cont_mode` is 0 and `req_ready` is 1.
- R2: A read (`req_kind` = 00b) issued while `cont_mode` is 0 begins with opcode EBh, sent MSB first, one bit per SCK rising edge on IO0, with `io_oe` = 0001b.
- R3: The address follows as six nibbles, most significant nibble first, on IO3..IO0 (IO3 holds the nibble MSB), with `io_oe` = 1111b.
- R4: The two nibbles after the address carry the mode byte (upper nibble first) with all lines driven. The byte is A0h when `req_cont` is 1 and 00h otherwise, and `cont_mode` then equals `req_cont`.
- R5: A read issued while `cont_mode` is 1 has no opcode, so its first SCK edge already carries the top address nibble.
- R6: The mode byte is followed by DUMMY SCK clocks (default 4) and then by the data phase, with `io_oe` = 0000b throughout both.
- R7: The read delivers exactly `req_len` bytes, each assembled from two nibbles sampled from `io_in` on SCK rising edges, upper nibble first. A count of 0 ends the frame right after the dummy clocks.
- R8: Between frames `cs_n` stays high for at least one SCK period (two system clocks), and `sck` is low whenever `cs_n` is high.
- R9: A mode-exit request (`req_kind` = 01b) sends one frame of eight SCK clocks with all four lines driven high, and then `cont_mode` is 0.
- R10: A software reset request (`req_kind` = 1xb) sends 66h and then 99h as two separate single-line frames. When `cont_mode` is 1, it sends the R9 mode-exit frame before them. `cont_mode` is 0 afterwards.
- R11: Requests are taken only while `req_ready` is 1. A request raised during a transaction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 2 | 00 read, 01 mode exit, 1x software reset |
| req_addr | input | 24 | Fetch start address |
| req_len | input | LENW | Fetch byte count |
| req_cont | input | 1 | Keep the flash in continuous-read state after this fetch |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | One-cycle pulse when a request has finished |
| cont_mode | output | 1 | Flash is believed to be in continuous-read state |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data line outputs |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Data line inputs |

## Verification
The bench contains a flash model that decodes every frame from the pins and tracks its own continuous-read state. A sequencer that dropped the opcode at the wrong moment, or sent the wrong mode byte, would therefore produce a misdecoded address and data stream, not only a wrong flag. Directed cases include an address ending in Ah on a non-continuous fetch, where a wrong design would leave the flash skipping opcodes. Other directed cases are a switch from continuous to non-continuous (the 00h byte must still go out with no opcode in front), a zero byte count, and a reset issued while continuous mode is active (a bare 66h would be read by the flash as address bits). A request raised mid-frame is also checked: a design that latched it would emit an extra frame.

// File: rtl/qspi_xip_seq.sv
`timescale 1ns/1ps
module qspi_xip_seq #(
  parameter int DUMMY = 4,
  parameter int LENW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic [23:0]     req_addr,
  input  logic [LENW-1:0] req_len,
  input  logic            req_cont,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  output logic            done,
  output logic            cont_mode,
  output logic            sck,
  output logic            cs_n,
  output logic [3:0]      io_out,
  output logic [3:0]      io_oe,
  input  logic [3:0]      io_in
);
  localparam int DW = $clog2(DUMMY + 1);
  localparam int CW = (LENW + 1 > DW) ? LENW + 1 : DW;

  localparam logic [2:0] S_IDLE = 3'd0, S_CMD = 3'd1, S_ADDR = 3'd2, S_MODE = 3'd3,
                         S_DUMMY = 3'd4, S_DATA = 3'd5, S_GAP = 3'd6;
  localparam logic [1:0] P_NONE = 2'd0, P_66 = 2'd1, P_99 = 2'd2;

  logic [2:0]      st;
  logic            ph;
  logic [CW-1:0]   cnt;
  logic [23:0]     sh;
  logic [7:0]      opc, mbyte;
  logic [1:0]      pend;
  logic            rdf, allf;
  logic [LENW-1:0] len_q;
  logic [3:0]      nib;

  assign req_ready = (st == S_IDLE);
  assign cs_n      = (st == S_IDLE) || (st == S_GAP);
  assign sck       = ph;

  always_comb begin
    io_out = 4'h0;
    io_oe  = 4'h0;
    case (st)
      S_CMD: begin
        io_out = allf ? 4'hF : {3'b000, opc[cnt[2:0]]};
        io_oe  = allf ? 4'hF : 4'h1;
      end
      S_ADDR: begin io_out = sh[23:20]; io_oe = 4'hF; end
      S_MODE: begin io_out = cnt[0] ? mbyte[7:4] : mbyte[3:0]; io_oe = 4'hF; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; cnt <= '0; sh <= '0; opc <= '0; mbyte <= '0;
      pend <= P_NONE; rdf <= 1'b0; allf <= 1'b0; len_q <= '0; nib <= '0;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; cont_mode <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          ph <= 1'b0;
          if (req_kind == 2'b00) begin
            rdf <= 1'b1; allf <= 1'b0; pend <= P_NONE;
            sh <= req_addr; len_q <= req_len;
            mbyte <= req_cont ? 8'hA0 : 8'h00;
            if (cont_mode) begin st <= S_ADDR; cnt <= CW'(5); end
            else begin st <= S_CMD; opc <= 8'hEB; cnt <= CW'(7); end
          end else begin
            rdf <= 1'b0; st <= S_CMD; cnt <= CW'(7);
            if (req_kind == 2'b01 || cont_mode) begin
              opc <= 8'hFF; allf <= 1'b1;
              pend <= req_kind[1] ? P_66 : P_NONE;
            end else begin
              opc <= 8'h66; allf <= 1'b0; pend <= P_99;
            end
          end
        end
        S_GAP: begin
          if (cnt == '0) begin
            if (pend != P_NONE) begin
              st <= S_CMD; cnt <= CW'(7); allf <= 1'b0; rdf <= 1'b0;
              opc  <= (pend == P_66) ? 8'h66 : 8'h99;
              pend <= (pend == P_66) ? P_99 : P_NONE;
            end else begin
              st <= S_IDLE; done <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          ph <= ~ph;
          if (!ph) begin
            if (st == S_DATA) begin
              if (cnt[0]) nib <= io_in;
              else begin rd_data <= {nib, io_in}; rd_valid <= 1'b1; end
            end
          end else begin
            if (st == S_ADDR) sh <= {sh[19:0], 4'h0};
            if (cnt == '0) begin
              case (st)
                S_CMD: if (rdf) begin st <= S_ADDR; cnt <= CW'(5); end
                       else begin
                         st <= S_GAP; cnt <= CW'(1);
                         if (allf || opc == 8'h99) cont_mode <= 1'b0;
                       end
                S_ADDR: begin st <= S_MODE; cnt <= CW'(1); end
                S_MODE: begin
                  cont_mode <= (mbyte[7:4] == 4'hA);
                  st <= S_DUMMY; cnt <= CW'(DUMMY - 1);
                end
                S_DUMMY: if (len_q == '0) begin st <= S_GAP; cnt <= CW'(1); end
                         else begin st <= S_DATA; cnt <= CW'({len_q, 1'b0}) - CW'(1); end
                default: begin st <= S_GAP; cnt <= CW'(1); end
              endcase
            end else cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/qspi_xip_seq_chk.sv
`timescale 1ns/1ps
module qspi_xip_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] io_oe,
  input logic       cont_mode,
  input logic       rd_valid,
  input logic [2:0] st
);
  localparam logic [2:0] S_ADDR = 3'd2, S_MODE = 3'd3, S_DUMMY = 3'd4, S_DATA = 3'd5;

  a_r8_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r8_cs_high_full_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  a_r6_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DUMMY || st == S_DATA) |-> io_oe == 4'h0);
  a_r3_all_lines_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR || st == S_MODE) |-> io_oe == 4'hF);
  a_r4_flag_set_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cont_mode) |-> $past(st) == S_MODE);
  a_r7_bytes_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(st) == S_DATA);
endmodule

bind qspi_xip_seq qspi_xip_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io_oe(io_oe),
  .cont_mode(cont_mode), .rd_valid(rd_valid), .st(st)
);

// File: tb/qspi_xip_seq_bench.sv
`timescale 1ns/1ps
module qspi_xip_seq_bench;
  localparam int DUMMY = 4;
  localparam int LENW  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_cont = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [23:0] req_addr = '0;
  logic [LENW-1:0] req_len = '0;
  logic req_ready, rd_valid, done, cont_mode, sck, cs_n;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = 4'h0;

  always #5 clk = ~clk;

  qspi_xip_seq #(.DUMMY(DUMMY), .LENW(LENW)) u_qspi_xip_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len), .req_cont(req_cont),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .cont_mode(cont_mode),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  int nchk = 0, nfail = 0;
  bit exp_cont = 1'b0;

  function automatic logic [7:0] memb(input logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h96;
  endfunction

  // flash model state, decoded from the pins
  bit fl_cont = 1'b0, last66 = 1'b0, f_start = 1'b0, f_allf = 1'b0, pcs = 1'b1, psck = 1'b0;
  int e = 0, gap = 0, gmin = 99, nfr = 0, oebad = 0, nrd = 0, base = 0, d = 0;
  logic [7:0] f_op = '0, f_mode = '0, lg_mode = '0, b = '0;
  logic [23:0] f_addr = '0, lg_addr = '0;
  logic [7:0] lg_op [0:3];
  bit lg_hasop [0:3];
  bit lg_allf [0:3];
  int lg_edges [0:3];
  logic [7:0] rdbuf [0:63];

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && nrd < 64) begin rdbuf[nrd] = rd_data; nrd++; end
      if (pcs && !cs_n) begin
        f_start = fl_cont; e = 0; f_op = '0; f_addr = '0; f_mode = '0; f_allf = 1'b1;
        if (nfr > 0 && gap < gmin) gmin = gap;
      end
      base = f_start ? 0 : 8;
      if (!cs_n && sck && !psck) begin
        if (io_out != 4'hF || io_oe != 4'hF) f_allf = 1'b0;
        if (!f_start && e < 8) begin
          f_op = {f_op[6:0], io_out[0]};
          if (!io_oe[0]) oebad++;
        end else if (e - base < 6) begin
          f_addr = {f_addr[19:0], io_out};
          if (io_oe != 4'hF) oebad++;
        end else if (e - base < 8) begin
          f_mode = {f_mode[3:0], io_out};
          if (io_oe != 4'hF) oebad++;
        end else if (io_oe != 4'h0) oebad++;
        e++;
      end
      if (!cs_n && !sck && psck && (f_start || f_op == 8'hEB) && e >= base + 8 + DUMMY) begin
        d = e - (base + 8 + DUMMY);
        b = memb(f_addr + 24'(d / 2));
        io_in = (d % 2 == 0) ? b[7:4] : b[3:0];
      end
      if (!pcs && cs_n) begin
        if (nfr < 4) begin
          lg_hasop[nfr] = !f_start; lg_op[nfr] = f_op; lg_edges[nfr] = e; lg_allf[nfr] = f_allf;
        end
        lg_addr = f_addr; lg_mode = f_mode; nfr++;
        if ((f_start || f_op == 8'hEB) && e >= base + 8) fl_cont = (f_mode[7:4] == 4'hA);
        else if (!f_start && e == 8 && (f_op == 8'hFF || (f_op == 8'h99 && last66))) fl_cont = 1'b0;
        last66 = !f_start && e == 8 && f_op == 8'h66;
        gap = 0;
      end
      if (cs_n) gap++;
      pcs = cs_n; psck = sck;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [23:0] a, input int len,
                       input bit cont, input bit poke);
    nfr = 0; oebad = 0; nrd = 0; gmin = 99;
    @(negedge clk);
    req_kind = kind; req_addr = a; req_len = LENW'(len); req_cont = cont; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(!req_ready, "R11 ready low while busy", 32'(req_ready), 0);
      req_kind = 2'b01; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_kind = 2'b00;
    end
    begin
      int t = 0;
      while (!done && t < 4000) begin @(negedge clk); t++; end
      chk(done == 1'b1, "R8 request completes", 32'(done), 1);
    end
  endtask

  task automatic do_read(input logic [23:0] a, input int len, input bit cont, input bit poke);
    bit hasop;
    hasop = !exp_cont;
    issue(2'b00, a, len, cont, poke);
    chk(nfr == 1, "R11 single frame per read", 32'(nfr), 1);
    chk(lg_hasop[0] == hasop, "R5 opcode presence", 32'(lg_hasop[0]), 32'(hasop));
    if (hasop) chk(lg_op[0] == 8'hEB, "R2 read opcode", 32'(lg_op[0]), 32'hEB);
    chk(lg_addr == a, "R3 address nibbles", 32'(lg_addr), 32'(a));
    chk(lg_mode == (cont ? 8'hA0 : 8'h00), "R4 mode byte", 32'(lg_mode), cont ? 32'hA0 : 0);
    chk(lg_edges[0] == (hasop ? 8 : 0) + 8 + DUMMY + 2 * len, "R6 clock count",
        32'(lg_edges[0]), 32'((hasop ? 8 : 0) + 8 + DUMMY + 2 * len));
    chk(oebad == 0, "R6 output enables per phase", 32'(oebad), 0);
    chk(nrd == len, "R7 byte count", 32'(nrd), 32'(len));
    for (int i = 0; i < len && i < nrd; i++)
      chk(rdbuf[i] == memb(a + 24'(i)), "R7 data byte", 32'(rdbuf[i]), 32'(memb(a + 24'(i))));
    chk(cont_mode == cont, "R4 flag after read", 32'(cont_mode), 32'(cont));
    chk(fl_cont == cont, "R4 flash state after read", 32'(fl_cont), 32'(cont));
    exp_cont = cont;
  endtask

  task automatic do_exit();
    issue(2'b01, 24'h0, 0, 1'b0, 1'b0);
    chk(nfr == 1 && lg_edges[0] == 8, "R9 one eight-clock frame", 32'(lg_edges[0]), 8);
    chk(lg_allf[0], "R9 all lines high", 32'(lg_allf[0]), 1);
    chk(!cont_mode && !fl_cont, "R9 flag cleared", 32'(cont_mode), 0);
    exp_cont = 1'b0;
  endtask

  task automatic do_reset();
    int first;
    first = exp_cont ? 1 : 0;
    issue(2'b10, 24'h0, 0, 1'b0, 1'b0);
    chk(nfr == 2 + first, "R10 frame count", 32'(nfr), 32'(2 + first));
    if (first == 1) chk(lg_allf[0] && lg_edges[0] == 8, "R10 exit frame first", 32'(lg_allf[0]), 1);
    chk(lg_op[first] == 8'h66 && lg_hasop[first], "R10 reset enable", 32'(lg_op[first]), 32'h66);
    chk(lg_op[first + 1] == 8'h99, "R10 reset command", 32'(lg_op[first + 1]), 32'h99);
    chk(gmin >= 2, "R8 deselect gap", 32'(gmin), 2);
    chk(!cont_mode && !fl_cont, "R10 flag cleared", 32'(cont_mode), 0);
    exp_cont = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R8 actual=hung expected=completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n at reset", 32'(cs_n), 1);
    chk(sck == 1'b0 && io_oe == 4'h0, "R1 sck and enables at reset", {27'd0, sck, io_oe}, 0);
    chk(cont_mode == 1'b0 && req_ready == 1'b1, "R1 flag and ready", {30'd0, cont_mode, req_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_read(24'h12345A, 3, 1'b0, 1'b0);
    do_read(24'h00010A, 2, 1'b0, 1'b0);
    do_read(24'hABCDE0, 4, 1'b1, 1'b0);
    do_read(24'h000100, 5, 1'b1, 1'b0);
    do_read(24'hFFFFFE, 3, 1'b0, 1'b0);
    do_read(24'h00300A, 0, 1'b0, 1'b0);
    do_read(24'h420000, 2, 1'b1, 1'b1);
    do_exit();
    do_read(24'h000777, 1, 1'b1, 1'b0);
    do_reset();
    do_reset();
    do_exit();

    for (int n = 0; n < 60; n++) begin
      int r;
      logic [23:0] a;
      r = $urandom % 10;
      a = 24'($urandom);
      if (r == 0) a[3:0] = 4'hA;
      if (r < 8) do_read(a, $urandom % 9, 1'($urandom), 1'b0);
      else if (r == 8) do_exit();
      else do_reset();
    end
    finish_run();
  end
endmodule